// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Posting

This block gathers interrupt conditions from a set of hardware sources and records each one in a posted flag. A posted flag stays set until software or the CPU retires it. A per-source enable bit then decides whether a posted flag counts as pending. A fixed-priority encoder picks the pending source with the lowest index. It presents an 8-bit vector, which is the low byte of the handler address. The CPU request is raised whenever something is pending and the global enable input is high.

Two kinds of source are supported, chosen per source by a parameter bit. A direct source posts on any clock edge at which its input is high. An edge source posts once per rising edge. The edge source registers its input and posts one cycle after the edge is sampled. Software reaches two registers over a small register bus. One is the enable register. The other is the posted register: reading it returns the posted flags, and writing a 0 to a bit retires that flag. An acknowledge input retires the flag of the source whose vector is on the output in that cycle.

The block has no state machine. Its only sequencing is the two-register edge detector, and everything else is combinational over the posted and enable registers.

Top module: `intc_prio_ctrl`

## Requirements
- R1: After reset, every posted flag and every enable bit is 0, `irq_o` is 0 and `vector_o` is 0.
- R2: A direct source (EDGE_MASK bit 0) whose `evt_i` bit is 1 at a rising clock edge has its posted flag set from that edge onward.
- R3: An edge source (EDGE_MASK bit 1) posts once per 0-to-1 change of its input. The flag appears two clock edges after the input rises. An input that stays high does not post again after its flag is retired.
- R4: A source is pending only when its posted flag and its enable bit are both 1. A posted flag survives while its source is disabled, and it raises the request as soon as the enable bit is written to 1.
- R5: `irq_o` is 1 exactly when some source is pending and `gie_i` is 1, with no clock delay. A 0-to-1 change of `gie_i` while a source is pending raises `irq_o` in the same cycle.
- R6: The pending source with the lowest index wins. `vector_o` equals VEC_BASE + VEC_STEP*index, which is 4 + 4*i by default, and it is 0 when nothing is pending.
- R7: `ack_i` high at a clock edge retires only the posted flag of the source whose vector is presented in that cycle. With nothing pending it has no effect.
- R8: A bus write to address 1 retires each posted flag whose write-data bit is 0. Flags whose write-data bit is 1 keep their value.
- R9: A new event on a source at the same edge as a retiring write or an acknowledge for that source leaves its posted flag set.
- R10: The bus read data is combinational. Address 0 returns the enable register, and address 1 returns the posted flags. A bus write to address 0 loads the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Interrupt condition per source |
| gie_i | input | 1 | Global interrupt enable from the CPU flags |
| ack_i | input | 1 | CPU has taken the presented interrupt |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 enable, 1 posted |
| bus_wdata_i | input | NUM_SRC | Register write data |
| bus_rdata_o | output | NUM_SRC | Register read data |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 8 | Low byte of the handler address |

## Verification
The following are checked on every cycle:
- `irq_o` never rises without `gie_i`.
- A raised request always carries a vector in the valid range.
- A posted flag never drops unless an acknowledge or a posted-register write occurs.
- An acknowledge retires the flag behind the vector that was presented.
- A global-enable rise with work pending raises the request immediately.

Other behaviours need the bench's scenarios, because they depend on ordered stimulus:
- the priority order and vector arithmetic, across all 256 enable patterns;
- the extra cycle an edge source takes, and that a held input posts only once;
- the late-enable case;
- the precedence of a new event over a retire in the same cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int VEC_W = 8;

    typedef enum logic [0:0] {
        REG_ENABLE = 1'b0,
        REG_POSTED = 1'b1
    } intc_reg_e;
endpackage

// File: rtl/intc_evt_capture.sv
module intc_evt_capture #(
    parameter int              NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] set_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            logic smp_q;
            logic prv_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    smp_q <= 1'b0;
                    prv_q <= 1'b0;
                end else begin
                    smp_q <= evt_i[i];
                    prv_q <= smp_q;
                end
            end

            assign set_o[i] = smp_q & ~prv_q;
        end else begin : g_direct
            assign set_o[i] = evt_i[i];
        end
    end
endmodule

// File: rtl/intc_post_bank.sv
module intc_post_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] posted_o
);
    logic [NUM_SRC-1:0] posted_q;

    // A new event wins over a retire on the same source.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            posted_q <= '0;
        end else begin
            posted_q <= (posted_q & ~clr_i) | set_i;
        end
    end

    assign posted_o = posted_q;
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int NUM_SRC  = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]           pending_i,
    output logic                         any_o,
    output logic [NUM_SRC-1:0]           grant_o,
    output logic [intc_pkg::VEC_W-1:0]   vector_o
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = '0;
        grant_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending_i[i]) begin
                idx     = IDX_W'(i);
                grant_o = NUM_SRC'(1) << i;
            end
        end
    end

    assign any_o    = |pending_i;
    assign vector_o = any_o ? intc_pkg::VEC_W'(VEC_BASE + VEC_STEP * int'(idx))
                            : '0;
endmodule

// File: rtl/intc_prio_ctrl.sv
module intc_prio_ctrl #(
    parameter int                 NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 8'hF0,
    parameter int                 VEC_BASE  = 4,
    parameter int                 VEC_STEP  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           evt_i,
    input  logic                         gie_i,
    input  logic                         ack_i,
    input  logic                         bus_wr_i,
    input  logic                         bus_addr_i,
    input  logic [NUM_SRC-1:0]           bus_wdata_i,
    output logic [NUM_SRC-1:0]           bus_rdata_o,
    output logic                         irq_o,
    output logic [intc_pkg::VEC_W-1:0]   vector_o
);
    import intc_pkg::*;

    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] posted_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clr_vec;
    logic               any_pend;
    intc_reg_e          reg_sel;

    assign reg_sel = intc_reg_e'(bus_addr_i);

    intc_evt_capture #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .set_o (set_vec)
    );

    always_comb begin
        clr_vec = '0;
        if (bus_wr_i && reg_sel == REG_POSTED) begin
            clr_vec = ~bus_wdata_i;
        end
        if (ack_i) begin
            clr_vec = clr_vec | grant;
        end
    end

    intc_post_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_posted (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .posted_o (posted_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (bus_wr_i && reg_sel == REG_ENABLE) begin
            mask_q <= bus_wdata_i;
        end
    end

    assign pending = posted_q & mask_q;

    intc_prio_enc #(
        .NUM_SRC  (NUM_SRC),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_enc (
        .pending_i (pending),
        .any_o     (any_pend),
        .grant_o   (grant),
        .vector_o  (vector_o)
    );

    always_comb begin
        unique case (reg_sel)
            REG_ENABLE: bus_rdata_o = mask_q;
            REG_POSTED: bus_rdata_o = posted_q;
            default:    bus_rdata_o = '0;
        endcase
    end

    assign irq_o = any_pend & gie_i;
endmodule

// File: rtl/intc_prio_ctrl_chk.sv
module intc_prio_ctrl_chk #(
    parameter int NUM_SRC  = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       gie_i,
    input logic                       ack_i,
    input logic                       bus_wr_i,
    input logic                       bus_addr_i,
    input logic                       irq_o,
    input logic [intc_pkg::VEC_W-1:0] vector_o,
    input logic [NUM_SRC-1:0]         posted,
    input logic [NUM_SRC-1:0]         mask,
    input logic [NUM_SRC-1:0]         set_vec
);
    logic [IDX_W-1:0] sel_idx;
    int               sel_raw;

    always_comb begin
        sel_raw = (int'(vector_o) - VEC_BASE) / VEC_STEP;
        if (vector_o == '0 || sel_raw < 0 || sel_raw >= NUM_SRC) begin
            sel_idx = '0;
        end else begin
            sel_idx = IDX_W'(sel_raw);
        end
    end

    p_irq_needs_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_i);

    p_irq_vector_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (int'(vector_o) >= VEC_BASE &&
                   int'(vector_o) < VEC_BASE + VEC_STEP * NUM_SRC));

    p_gie_rise_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gie_i) && |(posted & mask)) |-> irq_o);

    p_posted_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !(bus_wr_i && bus_addr_i)) |=>
            ((posted & $past(posted)) == $past(posted)));

    p_ack_retires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && vector_o != '0 && !set_vec[sel_idx]) |=>
            !posted[$past(sel_idx)]);
endmodule

bind intc_prio_ctrl intc_prio_ctrl_chk #(
    .NUM_SRC  (NUM_SRC),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gie_i      (gie_i),
    .ack_i      (ack_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .irq_o      (irq_o),
    .vector_o   (vector_o),
    .posted     (posted_q),
    .mask       (mask_q),
    .set_vec    (set_vec)
);

// File: tb/intc_prio_ctrl_test.sv
`timescale 1ns/1ps
module intc_prio_ctrl_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         gie_i = 1'b0;
    logic         ack_i = 1'b0;
    logic         bus_wr_i = 1'b0;
    logic         bus_addr_i = 1'b1;
    logic [N-1:0] bus_wdata_i = '0;
    logic [N-1:0] bus_rdata_o;
    logic         irq_o;
    logic [7:0]   vector_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    intc_prio_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .gie_i       (gie_i),
        .ack_i       (ack_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .vector_o    (vector_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_vec(input int m);
        for (int i = 0; i < N; i++) if (m[i]) return 4 + 4 * i;
        return 0;
    endfunction

    task automatic wr_reg(input logic a, input logic [N-1:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_addr_i = 1'b1;
    endtask

    task automatic rd_posted(output int v);
        bus_addr_i = 1'b1; #1; v = int'(bus_rdata_o);
    endtask

    task automatic pulse(input logic [N-1:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 vector", int'(vector_o), 0);
        rd_posted(v); chk("R1 posted", v, 0);
        bus_addr_i = 1'b0; #1; chk("R1 enable", int'(bus_rdata_o), 0);
        bus_addr_i = 1'b1;

        // R2 direct source posts at the sampling edge
        evt_i = 8'h04;
        @(negedge clk);
        evt_i = '0;
        rd_posted(v); chk("R2 direct post", v, 8'h04);

        // R8 write of 1 keeps, write of 0 retires
        wr_reg(1'b1, 8'hFF);
        rd_posted(v); chk("R8 ones keep", v, 8'h04);
        wr_reg(1'b1, 8'hFB);
        rd_posted(v); chk("R8 zero retires", v, 8'h00);

        // R3 edge source posts one cycle later, held input posts once
        evt_i = 8'h20;
        @(negedge clk);
        rd_posted(v); chk("R3 edge not yet", v, 8'h00);
        @(negedge clk);
        rd_posted(v); chk("R3 edge posted", v, 8'h20);
        wr_reg(1'b1, 8'hDF);
        rd_posted(v); chk("R3 retired", v, 8'h00);
        repeat (3) @(negedge clk);
        rd_posted(v); chk("R3 held high no repost", v, 8'h00);
        evt_i = '0;
        repeat (3) @(negedge clk);
        rd_posted(v); chk("R3 fall no post", v, 8'h00);

        // R4 late enable raises the request
        gie_i = 1'b1;
        pulse(8'h02);
        chk("R4 masked no irq", int'(irq_o), 0);
        rd_posted(v); chk("R4 still posted", v, 8'h02);
        wr_reg(1'b0, 8'h02);
        chk("R4 late enable irq", int'(irq_o), 1);
        chk("R6 vector src1", int'(vector_o), 8);

        // R5 gie rising with pending work
        gie_i = 1'b0; #1;
        chk("R5 gie low", int'(irq_o), 0);
        gie_i = 1'b1; #1;
        chk("R5 gie rise", int'(irq_o), 1);
        gie_i = 1'b0;
        wr_reg(1'b1, 8'h00);

        // R4/R5/R6/R10 sweep of every enable pattern with all sources posted
        pulse(8'hFF);
        rd_posted(v); chk("R2 R3 all posted", v, 8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr_reg(1'b0, 8'(m));
            bus_addr_i = 1'b0; #1;
            chk("R10 enable readback", int'(bus_rdata_o), m);
            bus_addr_i = 1'b1;
            chk("R6 vector", int'(vector_o), exp_vec(m));
            chk("R5 irq gie0", int'(irq_o), 0);
            gie_i = 1'b1; #1;
            chk("R5 irq gie1", int'(irq_o), (m != 0) ? 1 : 0);
            gie_i = 1'b0;
        end

        // R7 acknowledge walks the priority order
        wr_reg(1'b0, 8'hFF);
        gie_i = 1'b1;
        for (int k = 0; k < N; k++) begin
            chk("R7 vector order", int'(vector_o), 4 + 4 * k);
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            rd_posted(v); chk("R7 only presented retired", v, (8'hFF << (k + 1)) & 8'hFF);
        end
        chk("R6 idle vector", int'(vector_o), 0);
        chk("R7 idle irq", int'(irq_o), 0);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        rd_posted(v); chk("R7 idle ack no effect", v, 0);

        // R9 new event beats acknowledge and retiring write
        pulse(8'h01);
        ack_i = 1'b1; evt_i = 8'h01;
        @(negedge clk);
        ack_i = 1'b0; evt_i = '0;
        rd_posted(v); chk("R9 event beats ack", v, 8'h01);
        pulse(8'h02);
        evt_i = 8'h02;
        wr_reg(1'b1, 8'h00);
        evt_i = '0;
        rd_posted(v); chk("R9 event beats clear", v, 8'h02);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule